// File: doc/BRIEF.md
# Memory Controller Performance Monitor

This block watches a memory controller through a vector of single-cycle event strobes and keeps several 32-bit tallies. Software reaches it through a plain word-addressed register port. Slot 0 is a free-running clock-cycle tally. Every other slot counts the strobe chosen by its own 8-bit event code. Typical codes are 0x04 for read accesses, 0x05 for write accesses, 0x31 for precharges, 0x32 for activates and 0x37 for refreshes.

The cycle tally acts as the time base for the whole unit. When it wraps, it flags its overflow, raises a level interrupt and freezes every slot. Software then reads the event tallies, disables the cycle slot to lift the freeze, clears it and enables it again. A parameter decides what an event slot does when it runs past its top value: it either rolls over and keeps going, or it holds at the top value until it is cleared.

Top module: `mem_perf_monitor`

## Requirements
- R1: Slot n has its control word at byte address 4*n and its read-only count at byte address 0x20 + 4*n. Read data follows `busAddr` combinationally. An unmapped or unaligned address reads 0, and a write to it has no effect.
- R2: In a control word, bit 0 is the overflow flag, bit 1 is the clear bit, bit 2 is the enable bit and bits 31:24 hold the event code. Bit 0 is set only by hardware, and writing it has no effect.
- R3: Slot 0 adds one on every clock while it is enabled and not frozen. Its event code always reads 0, whatever is written to it.
- R4: An event slot adds one in each cycle where it is enabled, the unit is not frozen, and `evtStrobe[code]` is high. A code at or above EVT_W never counts.
- R5: When slot 0 steps past its all-ones value, it becomes 0 and sets its overflow flag. `irq` rises at the same time, and from the next cycle on no slot counts.
- R6: A write to control word 0 with the enable bit at 0 lifts the freeze. Counting resumes in the slots that are enabled.
- R7: `irq` equals the overflow flag of slot 0. It stays high until slot 0 is cleared. A write that sets the clear bit of slot 0 clears the slot only when the stored clear bit of slot 0 is 0.
- R8: A write of 0 to the clear bit of an event slot zeroes its count and its overflow flag. That clear bit always reads back as 1.
- R9: A control write that does not clear the slot (clear bit 1 on an event slot, or 0 on slot 0) leaves the count unchanged, even when the enable bit changes.
- R10: With STOP_ON_OVF=0, an event slot that steps past all-ones wraps to 0, sets its overflow flag and keeps counting.
- R11: With STOP_ON_OVF=1, an event slot that reaches all-ones sets its overflow flag and holds that value. It counts again only after it is cleared.
- R12: If a clear and a counted strobe hit the same slot in the same cycle, the clear wins and the count is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| evtStrobe | input | EVT_W | Single-cycle event strobes, indexed by event code |
| irq | output | 1 | Level interrupt, slot 0 overflow |

## Verification
Two functions can act on the same slot in the same edge: a software clear, and a counted strobe (or, on slot 0, the wrap). The bench holds the selected strobe high continuously while it writes the clearing control word. It expects the count to read 0 immediately after that edge, and to resume from 0 on the following edges. A second case overlaps the cycle wrap with event counting. In the wrap edge itself the event slots still count, and from the next edge they are frozen. The bench checks the exact event total it predicts.

// File: rtl/mem_perf_pkg.sv
package mem_perf_pkg;
  localparam int SEL_W   = 8;
  localparam int BIT_OVF = 0;
  localparam int BIT_CLR = 1;
  localparam int BIT_EN  = 2;
  localparam int SEL_LSB = 24;

  // Per-slot command from control to datapath
  typedef struct packed {
    logic             clear;     // zero count and overflow this edge
    logic             unfreeze;  // lift global freeze (slot 0 only)
    logic             enable;    // stored enable
    logic [SEL_W-1:0] sel;       // event code
  } cntCmd_t;
endpackage

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import mem_perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busValid,
  input  logic                              busWrite,
  input  logic [7:0]                        busAddr,
  input  logic [31:0]                       busWdata,
  output logic [31:0]                       busRdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]     cntVal,
  input  logic [NUM_CNT-1:0]                ovfFlag,
  output cntCmd_t [NUM_CNT-1:0]             cmd
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic [NUM_CNT-1:0]            enReg;
  logic [NUM_CNT-1:0][SEL_W-1:0] selReg;
  logic                          clr0Reg;
  logic [NUM_CNT-1:0]            wrHit;
  logic                          aligned, isCtrl, isCount, slotOk;
  logic [IDX_W-1:0]              idx;
  logic                          wdUnused;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign isCtrl   = (busAddr[7:5] == 3'd0) && aligned;
  assign isCount  = (busAddr[7:5] == 3'd1) && aligned;
  assign slotOk   = int'(busAddr[4:2]) < NUM_CNT;
  assign idx      = busAddr[2 +: IDX_W];
  assign wdUnused = ^busWdata[SEL_LSB-1:BIT_EN+1];

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++)
      wrHit[n] = busValid && busWrite && isCtrl && (busAddr[4:2] == 3'(n));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      selReg  <= '0;
      clr0Reg <= 1'b0;
    end else begin
      for (int n = 0; n < NUM_CNT; n++) begin
        if (wrHit[n]) begin
          enReg[n] <= busWdata[BIT_EN];
          if (n != 0) selReg[n] <= busWdata[SEL_LSB +: SEL_W];
        end
      end
      if (wrHit[0]) clr0Reg <= busWdata[BIT_CLR];
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++) begin
      cmd[n].enable = enReg[n];
      if (n == 0) begin
        cmd[n].sel      = '0;
        cmd[n].unfreeze = wrHit[0] && !busWdata[BIT_EN];
        cmd[n].clear    = wrHit[0] && busWdata[BIT_CLR] && !clr0Reg;
      end else begin
        cmd[n].sel      = selReg[n];
        cmd[n].unfreeze = 1'b0;
        cmd[n].clear    = wrHit[n] && !busWdata[BIT_CLR];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (slotOk && isCtrl) begin
      busRdata[SEL_LSB +: SEL_W] = (idx == '0) ? '0 : selReg[idx];
      busRdata[BIT_EN]           = enReg[idx];
      busRdata[BIT_CLR]          = (idx == '0) ? clr0Reg : 1'b1;
      busRdata[BIT_OVF]          = ovfFlag[idx];
    end else if (slotOk && isCount) begin
      busRdata[CNT_W-1:0] = cntVal[idx];
    end
  end
endmodule

// File: rtl/perf_datapath.sv
module perf_datapath
  import mem_perf_pkg::*;
#(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  parameter int EVT_W       = 64,
  parameter bit STOP_ON_OVF = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [EVT_W-1:0]              evtStrobe,
  input  cntCmd_t [NUM_CNT-1:0]         cmd,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CNT-1:0]            ovfFlag
);
  localparam int SIDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic frozen;
  logic cycleWrap;
  logic cmdUnused;

  assign cmdUnused = ^cmd;
  assign cycleWrap = cmd[0].enable && !frozen && !cmd[0].clear && (cntVal[0] == TOP);

  always_ff @(posedge clk) begin
    if (!rstN)                frozen <= 1'b0;
    else if (cycleWrap)       frozen <= 1'b1;
    else if (cmd[0].unfreeze) frozen <= 1'b0;
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
    logic [CNT_W-1:0] cntQ;
    logic             ovfQ;
    assign cntVal[n]  = cntQ;
    assign ovfFlag[n] = ovfQ;

    if (n == 0) begin : g_cycle
      always_ff @(posedge clk) begin
        if (!rstN || cmd[n].clear) begin
          cntQ <= '0;
          ovfQ <= 1'b0;
        end else if (cycleWrap) begin
          cntQ <= '0;
          ovfQ <= 1'b1;
        end else if (cmd[n].enable && !frozen) begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end else begin : g_event
      logic hit, step;
      assign hit  = (int'(cmd[n].sel) < EVT_W) && evtStrobe[cmd[n].sel[SIDX_W-1:0]];
      assign step = cmd[n].enable && !frozen && hit && !(STOP_ON_OVF && ovfQ);
      always_ff @(posedge clk) begin
        if (!rstN || cmd[n].clear) begin
          cntQ <= '0;
          ovfQ <= 1'b0;
        end else if (step) begin
          if (cntQ == TOP) begin
            ovfQ <= 1'b1;
            cntQ <= STOP_ON_OVF ? TOP : '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mem_perf_monitor.sv
module mem_perf_monitor
  import mem_perf_pkg::*;
#(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  parameter int EVT_W       = 64,
  parameter bit STOP_ON_OVF = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [EVT_W-1:0] evtStrobe,
  output logic             irq
);
  cntCmd_t [NUM_CNT-1:0]          cmd;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cntVal;
  logic [NUM_CNT-1:0]             ovfFlag;

  perf_ctrl #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .ovfFlag(ovfFlag), .cmd(cmd)
  );

  perf_datapath #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W),
                  .STOP_ON_OVF(STOP_ON_OVF)) u_dp (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .cmd(cmd),
    .cntVal(cntVal), .ovfFlag(ovfFlag)
  );

  assign irq = ovfFlag[0];
endmodule

// File: rtl/mem_perf_checker.sv
module mem_perf_checker #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busValid,
  input logic                          busWrite,
  input logic [7:0]                    busAddr,
  input logic [31:0]                   busRdata,
  input logic                          irq,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVal
);
  logic wr0;
  logic sinkUnused;
  assign wr0 = busValid && busWrite && (busAddr == 8'h00);
  assign sinkUnused = ^busRdata[23:2];

  // R7: without a write to control word 0 the interrupt never drops
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !wr0 |=> irq);

  // R5: interrupt rises only together with the cycle slot wrapping to 0
  p_irq_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (cntVal[0] == '0));

  // R5: once wrapped, the cycle slot is frozen on the next edge
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) && !wr0 |=> $stable(cntVal[0]));

  // R3: the cycle slot only steps by one or returns to zero
  p_cycle_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntVal[0]) |->
      (cntVal[0] == CNT_W'($past(cntVal[0]) + 1'b1)) || (cntVal[0] == '0));

  // R3: the event code of slot 0 always reads 0
  p_sel_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h00) |-> (busRdata[31:24] == 8'h00));

  // R8: the clear bit of an event slot always reads back as 1
  p_clr_readback_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h04) |-> busRdata[1]);
endmodule

bind mem_perf_monitor mem_perf_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .irq(irq), .cntVal(cntVal)
);

// File: tb/mem_perf_monitor_bench.sv
`timescale 1ns/1ps
module mem_perf_monitor_bench;
  localparam int EVT_W = 64;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = 8'hFC;
  logic [31:0] busWdata = '0;
  logic [EVT_W-1:0] evtStrobe = '0;
  logic [31:0] rdA, rdB;
  logic irqA, irqB;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mem_perf_monitor #(.CNT_W(CNT_W), .EVT_W(EVT_W), .STOP_ON_OVF(1'b0)) u_mem_perf_monitor (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdA),
    .evtStrobe(evtStrobe), .irq(irqA));

  mem_perf_monitor #(.CNT_W(CNT_W), .EVT_W(EVT_W), .STOP_ON_OVF(1'b1)) u_mem_perf_monitor_stop (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdB),
    .evtStrobe(evtStrobe), .irq(irqB));

  // {slot, code, strobe bit (FF = all), cycles, expected}
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 8'h04, 8'h04, 8'd5,  8'd5},
    {8'd2, 8'h05, 8'h04, 8'd7,  8'd0},
    {8'd3, 8'h32, 8'h32, 8'd3,  8'd3},
    {8'd1, 8'h37, 8'h37, 8'd12, 8'd12},
    {8'd2, 8'h50, 8'hFF, 8'd6,  8'd0},
    {8'd3, 8'h31, 8'hFF, 8'd9,  8'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busAddr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a);
    busAddr = a;
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state, R1/R2
    rd(8'h00); check("R2 reset ctrl0", rdA, 32'h0);
    rd(8'h04); check("R2 reset ctrl1", rdA, 32'h2);
    rd(8'h24); check("R1 reset count1", rdA, 32'h0);
    rd(8'h40); check("R1 unmapped read", rdA, 32'h0);
    check("R7 reset irq", {31'b0, irqA}, 32'h0);

    // R2: overflow bit not writable
    busWr(8'h04, 32'h0000_0003);
    rd(8'h04); check("R2 ovf write ignored", rdA, 32'h2);

    // R4: table of event selections
    for (int i = 0; i < 6; i++) begin
      logic [7:0] slot, code, sbit, ncyc, expv;
      {slot, code, sbit, ncyc, expv} = VEC[i];
      busWr(8'(slot * 4), {code, 24'h000004});
      evtStrobe = (sbit == 8'hFF) ? '1 : (64'b1 << sbit);
      repeat (ncyc) @(negedge clk);
      evtStrobe = '0;
      rd(8'(8'h20 + slot * 4));
      check($sformatf("R4 vector %0d", i), rdA, {24'b0, expv});
    end

    // R3: cycle slot, code ignored
    busWr(8'h00, 32'hAB00_0004);
    rd(8'h00); check("R3 ctrl0 code reads 0", rdA, 32'h4);
    repeat (10) @(negedge clk);
    rd(8'h20); check("R3 cycle count", rdA, 32'd10);
    // R9: disable without clear keeps count
    busWr(8'h00, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h20); check("R9 cycle disable keeps count", rdA, 32'd11);
    // R7: 0 then 1 clears slot 0
    busWr(8'h00, 32'h2);
    rd(8'h20); check("R7 cycle clear", rdA, 32'd0);
    busWr(8'h00, 32'h0);

    // R5/R10/R11: wrap with event slot 1 counting bit 4
    busWr(8'h04, 32'h0400_0004);
    evtStrobe = 64'b1 << 4;
    busWr(8'h00, 32'h4);
    repeat (300) @(negedge clk);
    check("R5 irq legacy", {31'b0, irqA}, 32'h1);
    check("R5 irq stop", {31'b0, irqB}, 32'h1);
    rd(8'h20); check("R5 cycle wrapped", rdA, 32'd0);
    rd(8'h24);
    check("R10 legacy wrapped total", rdA, 32'd1);
    check("R11 stop holds top", rdB, 32'hFF);
    rd(8'h04);
    check("R10 legacy ovf flag", rdA, 32'h0400_0007);
    check("R11 stop ovf flag", rdB, 32'h0400_0007);

    // R6: disable cycle slot lifts freeze
    busWr(8'h00, 32'h0);
    repeat (5) @(negedge clk);
    rd(8'h24);
    check("R6 legacy resumes", rdA, 32'd6);
    check("R11 stop still held", rdB, 32'hFF);
    check("R7 irq stays until clear", {31'b0, irqA}, 32'h1);
    busWr(8'h00, 32'h4);
    repeat (4) @(negedge clk);
    rd(8'h20); check("R6 cycle resumes", rdA, 32'd4);
    busWr(8'h00, 32'h2);
    rd(8'h20); check("R7 cycle cleared", rdA, 32'd0);
    check("R7 irq dropped", {31'b0, irqA}, 32'h0);

    // R8/R12: clear while strobe is high
    busWr(8'h04, 32'h0400_0004);
    rd(8'h24);
    check("R12 clear wins legacy", rdA, 32'd0);
    check("R12 clear wins stop", rdB, 32'd0);
    rd(8'h04); check("R8 ovf cleared, clr reads 1", rdA, 32'h0400_0006);
    repeat (3) @(negedge clk);
    evtStrobe = '0;
    rd(8'h24); check("R11 stop counts after clear", rdB, 32'd3);

    // R9: enable changes only
    busWr(8'h04, 32'h0400_0002);
    evtStrobe = 64'b1 << 4;
    repeat (4) @(negedge clk);
    evtStrobe = '0;
    rd(8'h24); check("R9 disabled keeps count", rdA, 32'd3);
    busWr(8'h04, 32'h0400_0006);
    rd(8'h24); check("R9 re-enable keeps count", rdA, 32'd3);
    evtStrobe = 64'b1 << 4;
    repeat (2) @(negedge clk);
    evtStrobe = '0;
    rd(8'h24); check("R4 counts after re-enable", rdA, 32'd5);

    finish();
  end
endmodule